// File: doc/BRIEF.md
# I2C Line Phase Sequencer

This block produces the wire-level phases of an I2C bus master on the two open-drain lines. Each line is represented by a drive-low enable that the block owns and a level read back from the pad. The block never drives a line high; a released line is pulled high by the external resistor. A higher-level controller uses the block to build bytes, addresses and ACK bits. It issues one line operation at a time (START, write one bit, read one bit, repeated START or STOP) and waits for the completion pulse.

Work is paced by a tick strobe that comes from outside the block. An operation takes at most one sub-step per tick. Every operation begins by pulling SCL low, except START, which needs no SCL edge. Every operation ends on its last line transition before the next SCL low edge. The gap until the controller's next command, together with the tick period, sets the bit rate. Once SCL is released, the block holds in a wait step until SCL actually reads high, so a slave can stretch the clock. The line levels pass through a parameterised input synchroniser before the sequencer uses them.

Top module: `i2c_phase_seq`

## Requirements
- R1: A command is accepted only while `busy` is low. Acceptance raises `busy` on the next clock. A command presented while `busy` is high is ignored and does not change the running operation.
- R2: START (op code 0) completes on the first tick after acceptance. It drives SDA low and leaves SCL released.
- R3: Write-bit (op code 1) works on successive ticks. Tick 1 drives SCL low. Tick 2 releases SDA when `cmd_wbit` is 1 or drives it low when it is 0. Tick 3 releases SCL. The bit completes on the first later tick that sees SCL high, so it takes 4 ticks without stretching. An ACK bit is written the same way.
- R4: Read-bit (op code 2) drives SCL low on tick 1 and releases both lines on tick 2. On the first later tick that sees SCL high, it captures SDA into `rd_bit` and completes, so it takes 3 ticks. An ACK bit is read the same way.
- R5: Repeated START (op code 3) works on successive ticks. Tick 1 drives SCL low, tick 2 releases SDA and tick 3 releases SCL. Tick 4 waits for SCL high. The following tick drives SDA low and completes, so it takes 5 ticks. It ends with SDA low and SCL released.
- R6: STOP (op code 4) works on successive ticks. Tick 1 drives SCL low, tick 2 drives SDA low and tick 3 releases SCL. Tick 4 waits for SCL high. The following tick releases SDA and completes, so it takes 5 ticks. It ends with both lines released.
- R7: While SCL is held low by another device after the block released it, no operation completes and `busy` stays high.
- R8: Every operation ends with SCL released. The drive enables change only on clock edges at which `tick` was high.
- R9: `done` is a one-cycle pulse that is high in the clock after the completing tick, with `busy` already low. The sub-step count restarts at zero, so the next operation has its nominal tick count.
- R10: During and after reset, both drive enables are low and `busy` and `done` are low.
- R11: Op codes 5 to 7 are not accepted: `busy` stays low and no line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sub-step pacing strobe |
| cmd_valid | input | 1 | Command pulse |
| cmd_op | input | 3 | Operation code (0 START, 1 write, 2 read, 3 repeated START, 4 STOP) |
| cmd_wbit | input | 1 | Bit value for write |
| scl_in | input | 1 | Level read from SCL pad |
| sda_in | input | 1 | Level read from SDA pad |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_drive_low | output | 1 | Pull SDA low when high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| rd_bit | output | 1 | SDA value captured by a read |

## Verification
The bench counts the ticks from acceptance to `done` for each operation type. A sequencer that skipped the SCL-high wait, or that merged two sub-steps into one tick, would finish early and show a wrong count. A slave holding SCL low must stall a write. A design that ignored stretching would pulse `done` while the line was still low. A stray command sent in the middle of a write must not add a second completion or change the written bit. After a write of 0, a repeated START must release SDA before it raises SCL, or it would end in the wrong state. Reads are run with the slave at both levels, so a stuck or inverted capture fails one of them.

// File: rtl/i2c_phase_pkg.sv
package i2c_phase_pkg;
  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_WRITE   = 3'd1,
    OP_READ    = 3'd2,
    OP_RESTART = 3'd3,
    OP_STOP    = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_REL  = 2'd2
  } act_e;

  localparam int unsigned OP_W    = 3;
  localparam int unsigned STEP_W  = 3;
  localparam int unsigned OP_LAST = 4;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_pipe
      logic [WIDTH-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
          pipe[0] <= d;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_phase_ctrl.sv
module i2c_phase_ctrl
  import i2c_phase_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            cmd_wbit,
  input  logic            scl_hi,
  output act_e            scl_act,
  output act_e            sda_act,
  output logic            cap_en,
  output logic            busy,
  output logic            done
);
  logic              busy_q, busy_n;
  op_e               op_q, op_n;
  logic              bit_q, bit_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              done_q, done_n;
  logic              finish;
  logic              op_ok;

  assign op_ok = (32'(cmd_op) <= OP_LAST);

  always_comb begin
    busy_n  = busy_q;
    op_n    = op_q;
    bit_n   = bit_q;
    step_n  = step_q;
    scl_act = ACT_HOLD;
    sda_act = ACT_HOLD;
    cap_en  = 1'b0;
    finish  = 1'b0;
    if (!busy_q) begin
      if (cmd_valid && op_ok) begin
        busy_n = 1'b1;
        op_n   = op_e'(cmd_op);
        bit_n  = cmd_wbit;
        step_n = '0;
      end
    end else if (tick) begin
      case (op_q)
        OP_START: begin
          sda_act = ACT_LOW;
          finish  = 1'b1;
        end
        OP_WRITE: begin
          case (step_q)
            3'd0: begin scl_act = ACT_LOW; step_n = step_q + 1'b1; end
            3'd1: begin sda_act = bit_q ? ACT_REL : ACT_LOW; step_n = step_q + 1'b1; end
            3'd2: begin scl_act = ACT_REL; step_n = step_q + 1'b1; end
            default: if (scl_hi) finish = 1'b1;
          endcase
        end
        OP_READ: begin
          case (step_q)
            3'd0: begin scl_act = ACT_LOW; step_n = step_q + 1'b1; end
            3'd1: begin
              sda_act = ACT_REL;
              scl_act = ACT_REL;
              step_n  = step_q + 1'b1;
            end
            default: if (scl_hi) begin cap_en = 1'b1; finish = 1'b1; end
          endcase
        end
        OP_RESTART, OP_STOP: begin
          case (step_q)
            3'd0: begin scl_act = ACT_LOW; step_n = step_q + 1'b1; end
            3'd1: begin
              sda_act = (op_q == OP_STOP) ? ACT_LOW : ACT_REL;
              step_n  = step_q + 1'b1;
            end
            3'd2: begin scl_act = ACT_REL; step_n = step_q + 1'b1; end
            3'd3: if (scl_hi) step_n = step_q + 1'b1;
            default: begin
              sda_act = (op_q == OP_STOP) ? ACT_REL : ACT_LOW;
              finish  = 1'b1;
            end
          endcase
        end
        default: finish = 1'b1;
      endcase
    end
    if (finish) begin
      busy_n = 1'b0;
      step_n = '0;
    end
    done_n = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_START;
      bit_q  <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      op_q   <= op_n;
      bit_q  <= bit_n;
      step_q <= step_n;
      done_q <= done_n;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/i2c_line_drv.sv
module i2c_line_drv
  import i2c_phase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e scl_act,
  input  act_e sda_act,
  input  logic cap_en,
  input  logic sda_hi,
  output logic scl_low,
  output logic sda_low,
  output logic rd_bit
);
  logic scl_q, sda_q, rd_q;
  logic scl_n, sda_n, rd_n;

  always_comb begin
    scl_n = scl_q;
    sda_n = sda_q;
    rd_n  = rd_q;
    if (scl_act == ACT_LOW)      scl_n = 1'b1;
    else if (scl_act == ACT_REL) scl_n = 1'b0;
    if (sda_act == ACT_LOW)      sda_n = 1'b1;
    else if (sda_act == ACT_REL) sda_n = 1'b0;
    if (cap_en)                  rd_n  = sda_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b0;
      sda_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      scl_q <= scl_n;
      sda_q <= sda_n;
      rd_q  <= rd_n;
    end
  end

  assign scl_low = scl_q;
  assign sda_low = sda_q;
  assign rd_bit  = rd_q;
endmodule

// File: rtl/i2c_phase_seq.sv
module i2c_phase_seq
  import i2c_phase_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            cmd_wbit,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            scl_drive_low,
  output logic            sda_drive_low,
  output logic            busy,
  output logic            done,
  output logic            rd_bit
);
  logic [1:0] pins_s;
  act_e       scl_act, sda_act;
  logic       cap_en;

  i2c_in_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (pins_s)
  );

  i2c_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wbit  (cmd_wbit),
    .scl_hi    (pins_s[1]),
    .scl_act   (scl_act),
    .sda_act   (sda_act),
    .cap_en    (cap_en),
    .busy      (busy),
    .done      (done)
  );

  i2c_line_drv u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_act (scl_act),
    .sda_act (sda_act),
    .cap_en  (cap_en),
    .sda_hi  (pins_s[0]),
    .scl_low (scl_drive_low),
    .sda_low (sda_drive_low),
    .rd_bit  (rd_bit)
  );
endmodule

// File: rtl/i2c_phase_seq_chk.sv
module i2c_phase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic busy,
  input logic done,
  input logic scl_drive_low,
  input logic sda_drive_low
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_scl_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scl_drive_low);

  a_r8_drive_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(scl_drive_low) && $stable(sda_drive_low)) |-> $past(tick));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(scl_drive_low) && $stable(sda_drive_low)));
endmodule

bind i2c_phase_seq i2c_phase_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .busy          (busy),
  .done          (done),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low)
);

// File: tb/test_i2c_phase_seq.sv
module test_i2c_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  typedef struct {
    string      req;
    logic       scl_low;
    logic       sda_low;
    logic       chk_rd;
    logic       rd;
    int         ticks;
  } item_t;

  logic clk, rst_n, tick, cmd_valid, cmd_wbit;
  logic [2:0] cmd_op;
  logic stretch, slave_low;
  logic scl_in, sda_in;
  logic scl_drive_low, sda_drive_low, busy, done, rd_bit;

  item_t sb[$];
  int n_chk, n_bad, tick_cnt;
  logic busy_prev;

  assign scl_in = !(scl_drive_low || stretch);
  assign sda_in = !(sda_drive_low || slave_low);

  i2c_phase_seq i_i2c_phase_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wbit(cmd_wbit), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .busy(busy), .done(done), .rd_bit(rd_bit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    tick = 1'b0;
    forever begin
      for (int k = 0; k < TICK_DIV; k++) begin
        @(negedge clk);
        tick = rst_n && (k == TICK_DIV-1);
      end
    end
  end

  // Monitor: samples a quarter period after each rising edge
  initial begin
    busy_prev = 1'b0;
    tick_cnt  = 0;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        if (tick && busy_prev) tick_cnt++;
        if (done) begin
          if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R1 unexpected done: actual 1 expected 0");
          end else begin
            item_t e;
            e = sb.pop_front();
            chk(e.req, "scl_drive_low", int'(scl_drive_low), int'(e.scl_low));
            chk(e.req, "sda_drive_low", int'(sda_drive_low), int'(e.sda_low));
            if (e.chk_rd) chk(e.req, "rd_bit", int'(rd_bit), int'(e.rd));
            if (e.ticks > 0) chk(e.req, "ticks", tick_cnt, e.ticks);
          end
          tick_cnt = 0;
        end
        busy_prev = busy;
      end
    end
  end

  task automatic issue(logic [2:0] op, logic b, string req, logic es, logic ed,
                       logic crd, logic erd, int et);
    item_t e;
    e.req = req; e.scl_low = es; e.sda_low = ed; e.chk_rd = crd; e.rd = erd; e.ticks = et;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_wbit = 1'b0;
    stretch = 1'b0; slave_low = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "scl_drive_low in reset", int'(scl_drive_low), 0);
    chk("R10", "sda_drive_low in reset", int'(sda_drive_low), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "busy after reset", int'(busy), 0);
    chk("R10", "done after reset", int'(done), 0);

    // R2 START
    issue(3'd0, 1'b0, "R2", 1'b0, 1'b1, 1'b0, 1'b0, 1);
    wait_idle();
    // R3 write 1 then 0 (same path as ACK write)
    issue(3'd1, 1'b1, "R3", 1'b0, 1'b0, 1'b0, 1'b0, 4);
    wait_idle();
    issue(3'd1, 1'b0, "R3", 1'b0, 1'b1, 1'b0, 1'b0, 4);
    wait_idle();
    // R5 repeated START after a 0 on SDA
    issue(3'd5 - 3'd2, 1'b0, "R5", 1'b0, 1'b1, 1'b0, 1'b0, 5);
    wait_idle();
    // R4 reads with slave high then low
    slave_low = 1'b0;
    issue(3'd2, 1'b0, "R4", 1'b0, 1'b0, 1'b1, 1'b1, 3);
    wait_idle();
    slave_low = 1'b1;
    issue(3'd2, 1'b0, "R4", 1'b0, 1'b0, 1'b1, 1'b0, 3);
    wait_idle();
    slave_low = 1'b0;
    // R6 STOP
    issue(3'd4, 1'b0, "R6", 1'b0, 1'b0, 1'b0, 1'b0, 5);
    wait_idle();

    // R1 stray command during a write
    issue(3'd1, 1'b1, "R1", 1'b0, 1'b0, 1'b0, 1'b0, 4);
    chk("R1", "busy after accept", int'(busy), 1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_wbit = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (8*TICK_DIV) @(negedge clk);
    chk("R1", "queue after stray command", sb.size(), 0);

    // R11 invalid op code
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R11", "busy for op 7", int'(busy), 0);
    repeat (4*TICK_DIV) @(negedge clk);
    chk("R11", "scl_drive_low for op 7", int'(scl_drive_low), 0);
    chk("R11", "sda_drive_low for op 7", int'(sda_drive_low), 0);

    // R7 clock stretching on a write
    stretch = 1'b1;
    issue(3'd1, 1'b0, "R7", 1'b0, 1'b1, 1'b0, 1'b0, 0);
    repeat (10*TICK_DIV) @(negedge clk);
    chk("R7", "busy while stretched", int'(busy), 1);
    chk("R7", "pending while stretched", sb.size(), 1);
    chk("R3", "scl released before wait", int'(scl_drive_low), 0);
    stretch = 1'b0;
    wait_idle();

    // R9 next operation keeps nominal timing
    issue(3'd1, 1'b1, "R9", 1'b0, 1'b0, 1'b0, 1'b0, 4);
    wait_idle();
    issue(3'd4, 1'b0, "R9", 1'b0, 1'b0, 1'b0, 1'b0, 5);
    wait_idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule